// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand specifier of a decoded instruction into the thing the execute stage needs. That is either an operand value or a memory effective address. Each request carries a four-bit mode code, two register indices, an address/displacement field, an immediate field, the current program counter, an operand size of 1, 2 or 4 bytes, and a push/pop select for stack mode.

The block reads the register file through two combinational read ports, indexed straight from the request. For memory-indirect mode it fetches the pointer word through a request/acknowledge memory read. The result is registered and comes with a one-cycle valid strobe. A flag tells the consumer whether the value is an operand or an address. For the pointer-updating modes, a register write-back is produced with the same strobe.

All address arithmetic is 32-bit and wraps modulo 2^32.

Top module: `opnd_ea_gen`

## Requirements
- R1: After reset `out_valid`, `wb_en`, `mem_req` and `busy` are all 0.
- R2: A request is accepted when `req_valid`=1 and `busy`=0. For every mode except memory-indirect (3) and the reserved codes (12 to 15), `out_valid` is 1 for exactly the one cycle after acceptance. Register mode (code 0) returns the contents of register `reg_a` with `out_is_addr`=0.
- R3: Immediate mode (code 1) returns `field_imm` with `out_is_addr`=0 and never raises `mem_req`.
- R4: Direct mode (code 2) returns the address `field_addr` with `out_is_addr`=1.
- R5: Memory-indirect mode (code 3) raises `mem_req`, with `mem_addr`=`field_addr`, from the cycle after acceptance. Both are held until a cycle with `mem_ack`=1. In the next cycle `out_valid`=1, `out_is_addr`=1 and the value is the `mem_rdata` captured with the acknowledge.
- R6: Register-indirect mode (code 4) returns the contents of `reg_a` as the address.
- R7: PC-relative mode (code 5) returns `pc` + `field_addr`, wrapping modulo 2^32.
- R8: Base mode (code 6) returns register `reg_a` + `field_addr`, with the displacement taken as unsigned and the sum wrapping.
- R9: Indexed mode returns `field_addr` + `reg_a` for code 7, and `field_addr` + `reg_a` + `reg_b` for code 8. Neither raises `wb_en`.
- R10: Auto-increment mode (code 9) returns the contents of `reg_a` as the address. In the same cycle it writes back `reg_a` + `opsize` to index `reg_a` (`wb_en`=1).
- R11: Auto-decrement mode (code 10) computes `reg_a` − `opsize` (wrapping). It returns that value as the address and also writes it back to `reg_a`.
- R12: Stack mode (code 11) uses register index `SP_IDX` (default 15) as the pointer and ignores `reg_a`. With `stk_push`=1 it pre-decrements; with `stk_push`=0 it post-increments, both by `opsize`.
- R13: While `busy`=1 (a pointer fetch is outstanding) a request is ignored and produces no strobe. A reserved mode code (12 to 15) produces no strobe and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| reg_a | input | RW | First register index (pointer/base/index) |
| reg_b | input | RW | Second index register for two-register indexing |
| field_addr | input | AW | Address or displacement field |
| field_imm | input | AW | Immediate field |
| pc | input | AW | Current program counter |
| opsize | input | 3 | Operand size in bytes: 1, 2 or 4 |
| stk_push | input | 1 | Stack mode: 1 push, 0 pop |
| rd_a_idx | output | RW | Register read port A index |
| rd_a_data | input | AW | Register read port A data |
| rd_b_idx | output | RW | Register read port B index |
| rd_b_data | input | AW | Register read port B data |
| mem_req | output | 1 | Pointer fetch request |
| mem_addr | output | AW | Pointer fetch address |
| mem_ack | input | 1 | Pointer fetch acknowledge |
| mem_rdata | input | AW | Pointer fetch data |
| busy | output | 1 | Pointer fetch outstanding |
| out_valid | output | 1 | Result strobe |
| out_is_addr | output | 1 | 1 = effective address, 0 = operand value |
| out_value | output | AW | Result |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | RW | Write-back register index |
| wb_data | output | AW | Write-back value |

## Verification
Every mode except memory-indirect registers its result at the edge that accepts the request. The bench therefore drives a request at a falling edge and samples the result and write-back at the next falling edge. At that point it also checks that nothing is still asserted.

For memory-indirect mode, the fetch request is visible from the first falling edge after acceptance. The bench holds the acknowledge off for several cycles and confirms that the address stays stable. It then raises the acknowledge for one cycle and checks the result one falling edge after that. A request issued during the fetch is then shown to produce no strobe.

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen #(
  parameter int AW     = 32,
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] reg_a,
  input  logic [RW-1:0] reg_b,
  input  logic [AW-1:0] field_addr,
  input  logic [AW-1:0] field_imm,
  input  logic [AW-1:0] pc,
  input  logic [2:0]    opsize,
  input  logic          stk_push,
  output logic [RW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_a_data,
  output logic [RW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_b_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          out_valid,
  output logic          out_is_addr,
  output logic [AW-1:0] out_value,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  localparam logic [3:0] M_REG   = 4'd0;
  localparam logic [3:0] M_IMM   = 4'd1;
  localparam logic [3:0] M_DIR   = 4'd2;
  localparam logic [3:0] M_MIND  = 4'd3;
  localparam logic [3:0] M_RIND  = 4'd4;
  localparam logic [3:0] M_PCREL = 4'd5;
  localparam logic [3:0] M_BASE  = 4'd6;
  localparam logic [3:0] M_IDX1  = 4'd7;
  localparam logic [3:0] M_IDX2  = 4'd8;
  localparam logic [3:0] M_AINC  = 4'd9;
  localparam logic [3:0] M_ADEC  = 4'd10;
  localparam logic [3:0] M_STACK = 4'd11;
  localparam logic [RW-1:0] SP_SEL = RW'(SP_IDX);

  logic          fetch_q;
  logic [AW-1:0] fetch_addr_q;
  logic          accept;
  logic [AW-1:0] size_w, ptr_inc, ptr_dec, idx_sum;
  logic          n_ok, n_is_addr, n_wb;
  logic [AW-1:0] n_value, n_wb_data;

  assign busy     = fetch_q;
  assign mem_req  = fetch_q;
  assign mem_addr = fetch_addr_q;
  assign accept   = req_valid && !fetch_q;

  assign rd_a_idx = (mode == M_STACK) ? SP_SEL : reg_a;
  assign rd_b_idx = reg_b;

  assign size_w  = AW'(opsize);
  assign ptr_inc = rd_a_data + size_w;
  assign ptr_dec = rd_a_data - size_w;
  assign idx_sum = field_addr + rd_a_data;

  always_comb begin
    n_ok      = 1'b1;
    n_is_addr = 1'b1;
    n_wb      = 1'b0;
    n_value   = '0;
    n_wb_data = '0;
    case (mode)
      M_REG: begin
        n_is_addr = 1'b0;
        n_value   = rd_a_data;
      end
      M_IMM: begin
        n_is_addr = 1'b0;
        n_value   = field_imm;
      end
      M_DIR:   n_value = field_addr;
      M_RIND:  n_value = rd_a_data;
      M_PCREL: n_value = pc + field_addr;
      M_BASE:  n_value = rd_a_data + field_addr;
      M_IDX1:  n_value = idx_sum;
      M_IDX2:  n_value = idx_sum + rd_b_data;
      M_AINC: begin
        n_value   = rd_a_data;
        n_wb      = 1'b1;
        n_wb_data = ptr_inc;
      end
      M_ADEC: begin
        n_value   = ptr_dec;
        n_wb      = 1'b1;
        n_wb_data = ptr_dec;
      end
      M_STACK: begin
        n_wb = 1'b1;
        if (stk_push) begin
          n_value   = ptr_dec;
          n_wb_data = ptr_dec;
        end else begin
          n_value   = rd_a_data;
          n_wb_data = ptr_inc;
        end
      end
      default: n_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q      <= 1'b0;
      fetch_addr_q <= '0;
      out_valid    <= 1'b0;
      out_is_addr  <= 1'b0;
      out_value    <= '0;
      wb_en        <= 1'b0;
      wb_idx       <= '0;
      wb_data      <= '0;
    end else if (fetch_q) begin
      wb_en     <= 1'b0;
      out_valid <= mem_ack;
      if (mem_ack) begin
        fetch_q     <= 1'b0;
        out_is_addr <= 1'b1;
        out_value   <= mem_rdata;
      end
    end else if (accept && mode == M_MIND) begin
      fetch_q      <= 1'b1;
      fetch_addr_q <= field_addr;
      out_valid    <= 1'b0;
      wb_en        <= 1'b0;
    end else if (accept) begin
      out_valid   <= n_ok;
      out_is_addr <= n_is_addr;
      out_value   <= n_value;
      wb_en       <= n_ok && n_wb;
      wb_idx      <= rd_a_idx;
      wb_data     <= n_wb_data;
    end else begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
    end
  end
endmodule

// File: rtl/opnd_ea_gen_chk.sv
module opnd_ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic [3:0]    mode,
  input logic [AW-1:0] field_imm,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic          out_is_addr,
  input logic [AW-1:0] out_value,
  input logic          wb_en
);
  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && mode != 4'd3 && mode < 4'd12) |=> out_valid); // R2
  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && mode == 4'd1) |=> (!mem_req && !out_is_addr && out_value == $past(field_imm))); // R3
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (out_valid && out_is_addr && !mem_req)); // R5
  AST_WB_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_valid && out_is_addr)); // R10
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && mode >= 4'd12) |=> (!out_valid && !wb_en)); // R13
endmodule

bind opnd_ea_gen opnd_ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .mode(mode),
  .field_imm(field_imm), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_is_addr(out_is_addr), .out_value(out_value), .wb_en(wb_en)
);

// File: tb/test_opnd_ea_gen.sv
module test_opnd_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, stk_push = 0, mem_ack = 0;
  logic [3:0]  mode = 0, reg_a = 0, reg_b = 0;
  logic [31:0] field_addr = 0, field_imm = 0, pc = 0, mem_rdata = 0;
  logic [2:0]  opsize = 4;
  logic [3:0]  rd_a_idx, rd_b_idx, wb_idx;
  logic [31:0] rd_a_data, rd_b_data, mem_addr, out_value, wb_data;
  logic        mem_req, busy, out_valid, out_is_addr, wb_en;
  logic [31:0] rf [16];
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_a_data = rf[rd_a_idx];
  assign rd_b_data = rf[rd_b_idx];

  opnd_ea_gen i_opnd_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .reg_a(reg_a),
    .reg_b(reg_b), .field_addr(field_addr), .field_imm(field_imm), .pc(pc),
    .opsize(opsize), .stk_push(stk_push), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .out_valid(out_valid),
    .out_is_addr(out_is_addr), .out_value(out_value), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [31:0] fa, input logic [31:0] fi, input logic [31:0] p,
                       input logic [2:0] sz, input logic push);
    @(negedge clk);
    mode = m; reg_a = ra; reg_b = rb; field_addr = fa; field_imm = fi;
    pc = p; opsize = sz; stk_push = push; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_res(input string tag, input logic isaddr, input logic [31:0] v,
                            input logic wbe, input logic [3:0] wi, input logic [31:0] wd);
    chk({tag, " valid"}, 32'(out_valid), 1);
    chk({tag, " is_addr"}, 32'(out_is_addr), 32'(isaddr));
    chk({tag, " value"}, out_value, v);
    chk({tag, " wb_en"}, 32'(wb_en), 32'(wbe));
    if (wbe) begin
      chk({tag, " wb_idx"}, 32'(wb_idx), 32'(wi));
      chk({tag, " wb_data"}, wb_data, wd);
      rf[wb_idx] = wb_data;
    end
    @(negedge clk);
    chk({tag, " strobe drops"}, 32'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 wb_en", 32'(wb_en), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 busy", 32'(busy), 0);
  endtask

  task automatic t_register;
    issue(4'd0, 4'd2, 0, 32'h55, 32'h66, 0, 4, 0);
    expect_res("R2 register", 0, rf[2], 0, 0, 0);
  endtask

  task automatic t_immediate;
    issue(4'd1, 4'd2, 0, 32'h55, 32'hCAFE_F00D, 0, 4, 0);
    chk("R3 no mem_req", 32'(mem_req), 0);
    expect_res("R3 immediate", 0, 32'hCAFE_F00D, 0, 0, 0);
  endtask

  task automatic t_direct;
    issue(4'd2, 4'd2, 0, 32'h0000_4000, 0, 0, 4, 0);
    expect_res("R4 direct", 1, 32'h0000_4000, 0, 0, 0);
  endtask

  task automatic t_indirect;
    issue(4'd3, 0, 0, 32'h0000_0800, 0, 0, 4, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R5 mem_req held", 32'(mem_req), 1);
      chk("R5 mem_addr", mem_addr, 32'h0000_0800);
      chk("R5 no early strobe", 32'(out_valid), 0);
      if (i == 1) begin
        mode = 4'd1; field_imm = 32'h1234; req_valid = 1;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    chk("R13 busy request ignored", 32'(out_valid), 0);
    mem_ack = 1; mem_rdata = 32'h0BAD_BEEF;
    @(negedge clk);
    mem_ack = 0; mem_rdata = 0;
    chk("R5 fetch released", 32'(mem_req), 0);
    expect_res("R5 indirect", 1, 32'h0BAD_BEEF, 0, 0, 0);
  endtask

  task automatic t_reg_ind;
    issue(4'd4, 4'd5, 0, 32'h99, 0, 0, 4, 0);
    expect_res("R6 reg indirect", 1, rf[5], 0, 0, 0);
  endtask

  task automatic t_pcrel;
    issue(4'd5, 0, 0, 32'h20, 0, 32'hFFFF_FFF0, 4, 0);
    expect_res("R7 pc-rel wrap", 1, 32'h0000_0010, 0, 0, 0);
    issue(4'd5, 0, 0, 32'hFFFF_FFF8, 0, 32'h100, 4, 0);
    expect_res("R7 pc-rel back", 1, 32'h0000_00F8, 0, 0, 0);
  endtask

  task automatic t_base;
    rf[6] = 32'hFFFF_0000;
    issue(4'd6, 4'd6, 0, 32'h0002_0000, 0, 0, 4, 0);
    expect_res("R8 base wrap", 1, 32'h0001_0000, 0, 0, 0);
  endtask

  task automatic t_index;
    rf[1] = 32'h10; rf[2] = 32'h2000;
    issue(4'd7, 4'd1, 4'd2, 32'h100, 0, 0, 4, 0);
    expect_res("R9 index one", 1, 32'h110, 0, 0, 0);
    issue(4'd8, 4'd1, 4'd2, 32'h100, 0, 0, 4, 0);
    expect_res("R9 index two", 1, 32'h2110, 0, 0, 0);
    chk("R9 index reg kept", rf[1], 32'h10);
  endtask

  task automatic t_autoinc;
    rf[3] = 32'h1000;
    issue(4'd9, 4'd3, 0, 0, 0, 0, 4, 0);
    expect_res("R10 ainc size4", 1, 32'h1000, 1, 4'd3, 32'h1004);
    issue(4'd9, 4'd3, 0, 0, 0, 0, 2, 0);
    expect_res("R10 ainc size2", 1, 32'h1004, 1, 4'd3, 32'h1006);
    issue(4'd9, 4'd3, 0, 0, 0, 0, 1, 0);
    expect_res("R10 ainc size1", 1, 32'h1006, 1, 4'd3, 32'h1007);
  endtask

  task automatic t_autodec;
    rf[4] = 32'h0;
    issue(4'd10, 4'd4, 0, 0, 0, 0, 2, 0);
    expect_res("R11 adec wrap", 1, 32'hFFFF_FFFE, 1, 4'd4, 32'hFFFF_FFFE);
    issue(4'd10, 4'd4, 0, 0, 0, 0, 4, 0);
    expect_res("R11 adec size4", 1, 32'hFFFF_FFFA, 1, 4'd4, 32'hFFFF_FFFA);
  endtask

  task automatic t_stack;
    rf[15] = 32'h2000; rf[7] = 32'h7777;
    issue(4'd11, 4'd7, 0, 0, 0, 0, 4, 1);
    expect_res("R12 push", 1, 32'h1FFC, 1, 4'd15, 32'h1FFC);
    issue(4'd11, 4'd7, 0, 0, 0, 0, 4, 0);
    expect_res("R12 pop", 1, 32'h1FFC, 1, 4'd15, 32'h2000);
    chk("R12 reg_a untouched", rf[7], 32'h7777);
  endtask

  task automatic t_reserved;
    for (int m = 12; m < 16; m++) begin
      issue(4'(m), 4'd3, 0, 32'h40, 32'h50, 0, 4, 0);
      chk("R13 reserved no strobe", 32'(out_valid), 0);
      chk("R13 reserved no wb", 32'(wb_en), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1111_0000 + 32'(i);
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_register;
    t_immediate;
    t_direct;
    t_indirect;
    t_reg_ind;
    t_pcrel;
    t_base;
    t_index;
    t_autoinc;
    t_autodec;
    t_stack;
    t_reserved;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule